// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a twisted-pair link is alive. It watches two kinds of evidence from the receive side: single-cycle strobes that mark received idle link pulses, and a level that is high while a data packet is being received. If neither kind of evidence arrives for a whole loss timeout, the link is declared failed. The block then raises a level that gates the transmit and receive paths, and it releases an active-low status line that drives an open-drain LED. The link recovers after a set number of consecutive link pulses or after one received packet.

The block also sets the pace of the idle link pulses on the transmit side. Whenever the transmitter is quiet, it issues a one-cycle request at a fixed interval. This generator runs whatever the link state is and whatever the check-enable input says.

A low check-enable input switches off the receive-side check only, and the datapaths stay enabled. A loopback test input forces the link-pass state. All timing runs on a prescaled tick of `TICK_DIV` clock cycles. The loss timeout, the idle interval and the recovery pulse count are parameters.

Top module: `tp_link_monitor`

## Requirements
- R1: While `rstN` is low at a rising clock edge (synchronous reset/power-down), the block enters link-fail and clears all timers and counters. After that edge `linkFail`=1, `linkStatusN`=1 and `idlePulseReq`=0.
- R2: `linkStatusN` is 0 exactly when the link is in pass (`linkFail`=0) and is 1 (released) in fail.
- R3: In pass, with `checkEnable`=1 and `testLoopback`=0, a stretch with no link pulse and with `rxDataActive` low drives the block to fail. The last evidence is sampled at edge E. `linkFail` rises at an edge between E+(LOSS_TICKS-1)*TICK_DIV+1 and E+LOSS_TICKS*TICK_DIV.
- R4: Every sampled `linkPulseIn` and every cycle with `rxDataActive` high restart the loss timer, so a link fed with evidence more often than the timeout stays in pass.
- R5: In fail, the block returns to pass at the edge that samples the PASS_PULSES-th link pulse. The pulses only count if no loss timeout expires between them; an expiry clears the count.
- R6: In fail, a rising edge of `rxDataActive` (one received packet) returns the block to pass at the edge that samples it.
- R7: While `checkEnable` is low, the block is in pass from the next edge on (`linkFail`=0), whatever pulses or data arrive or fail to arrive.
- R8: While `testLoopback` is high, the block is in pass from the next edge on, whatever evidence arrives.
- R9: With `txActive` low, `idlePulseReq` is a one-cycle strobe. It first appears after edge IDLE_TICKS*TICK_DIV counted from reset release and then repeats every IDLE_TICKS*TICK_DIV cycles, whatever the values of `checkEnable` and the link state.
- R10: No strobe is issued while `txActive` is high. When `txActive` falls, the interval restarts from zero at the next tick boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset / power-down |
| linkPulseIn | input | 1 | One-cycle strobe per received idle link pulse |
| rxDataActive | input | 1 | High while a packet is being received |
| txActive | input | 1 | High while the transmitter is sending data |
| testLoopback | input | 1 | High forces link-pass (loopback test) |
| checkEnable | input | 1 | Low disables the receive link check |
| linkStatusN | output | 1 | Active-low link-good status for the open-drain LED |
| linkFail | output | 1 | High gates the transmit and receive paths |
| idlePulseReq | output | 1 | One-cycle request to send an idle link pulse |

## Verification
The hardest condition to reach from the ports is a pulse count that a loss timeout has wiped out while the block stays in fail. The bench sends one pulse and then waits longer than the full timeout, so an expiry is certain to occur in between. A second pulse must then leave the link failed, and only a third pulse may restore it. The loss timeout is measured as a window of cycles, because the tick phase at the last evidence is unknown. The idle strobes are predicted exactly from reset release, and again after a gap in transmit activity.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;
  typedef enum logic {LINK_FAIL = 1'b0, LINK_PASS = 1'b1} linkState_e;

  // control -> datapath
  typedef struct packed {
    logic clrPulses;
  } fsmCmd_t;

  // datapath -> control
  typedef struct packed {
    logic lossExpire;
    logic pulseDone;
    logic packetStart;
  } tmrStat_t;
endpackage

// File: rtl/link_mon_timers.sv
module link_mon_timers
  import link_mon_pkg::*;
#(
  parameter int TICK_DIV    = 10000,
  parameter int LOSS_TICKS  = 100,
  parameter int IDLE_TICKS  = 16,
  parameter int PASS_PULSES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     linkPulseIn,
  input  logic     rxDataActive,
  input  logic     txActive,
  input  fsmCmd_t  cmd,
  output tmrStat_t stat,
  output logic     idlePulseReq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int LW = $clog2(LOSS_TICKS + 1);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam int CW = $clog2(PASS_PULSES + 1);
  localparam logic [PW-1:0] PRE_LAST   = PW'(TICK_DIV - 1);
  localparam logic [LW-1:0] LOSS_LAST  = LW'(LOSS_TICKS - 1);
  localparam logic [IW-1:0] IDLE_LAST  = IW'(IDLE_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PASS_PULSES - 1);

  logic [PW-1:0] preCnt;
  logic [LW-1:0] lossCnt;
  logic [IW-1:0] idleCnt;
  logic [CW-1:0] pulseCnt;
  logic tick, evidence, rxPrev, idleFire;

  // prescaler
  assign tick = (preCnt == PRE_LAST);
  always_ff @(posedge clk) begin
    if (!rstN || tick) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  // loss timer
  assign evidence        = linkPulseIn | rxDataActive;
  assign stat.lossExpire = tick && !evidence && (lossCnt == LOSS_LAST);
  always_ff @(posedge clk) begin
    if (!rstN || evidence || stat.lossExpire) lossCnt <= '0;
    else if (tick)                            lossCnt <= lossCnt + 1'b1;
  end

  // packet start detect
  always_ff @(posedge clk) begin
    if (!rstN) rxPrev <= 1'b0;
    else       rxPrev <= rxDataActive;
  end
  assign stat.packetStart = rxDataActive && !rxPrev;

  // consecutive pulse counter for recovery
  assign stat.pulseDone = linkPulseIn && (pulseCnt == PULSE_LAST);
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrPulses || stat.lossExpire) pulseCnt <= '0;
    else if (linkPulseIn)                          pulseCnt <= pulseCnt + 1'b1;
  end

  // idle pulse pacing
  assign idleFire = tick && !txActive && (idleCnt == IDLE_LAST);
  always_ff @(posedge clk) begin
    if (!rstN || txActive || idleFire) idleCnt <= '0;
    else if (tick)                     idleCnt <= idleCnt + 1'b1;
  end
  always_ff @(posedge clk) begin
    if (!rstN) idlePulseReq <= 1'b0;
    else       idlePulseReq <= idleFire;
  end

  p_req_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    idlePulseReq |=> !idlePulseReq)
    else $error("idle request longer than one cycle");
  p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    txActive |=> !idlePulseReq)
    else $error("idle request during transmit activity");
  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    evidence |=> !stat.lossExpire)
    else $error("loss expiry right after evidence");
endmodule

// File: rtl/link_mon_fsm.sv
module link_mon_fsm
  import link_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     testLoopback,
  input  logic     checkEnable,
  input  tmrStat_t stat,
  output fsmCmd_t  cmd,
  output logic     linkFail
);
  linkState_e state;

  always_ff @(posedge clk) begin
    if (!rstN)                             state <= LINK_FAIL;
    else if (testLoopback || !checkEnable) state <= LINK_PASS;
    else begin
      case (state)
        LINK_FAIL: if (stat.pulseDone || stat.packetStart) state <= LINK_PASS;
        LINK_PASS: if (stat.lossExpire)                    state <= LINK_FAIL;
        default:                                           state <= LINK_FAIL;
      endcase
    end
  end

  assign cmd.clrPulses = (state == LINK_PASS);
  assign linkFail      = (state == LINK_FAIL);

  p_force_r8: assert property (@(posedge clk) disable iff (!rstN)
    testLoopback |=> !linkFail)
    else $error("loopback test did not force pass");
  p_disable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !checkEnable |=> !linkFail)
    else $error("disabled check did not hold pass");
  p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (linkFail && checkEnable && !testLoopback && !stat.pulseDone && !stat.packetStart)
      |=> linkFail)
    else $error("left fail without evidence");
  p_pass_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!linkFail && !stat.lossExpire) |=> !linkFail)
    else $error("left pass without loss expiry");
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import link_mon_pkg::*;
#(
  parameter int TICK_DIV    = 10000,
  parameter int LOSS_TICKS  = 100,
  parameter int IDLE_TICKS  = 16,
  parameter int PASS_PULSES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkPulseIn,
  input  logic rxDataActive,
  input  logic txActive,
  input  logic testLoopback,
  input  logic checkEnable,
  output logic linkStatusN,
  output logic linkFail,
  output logic idlePulseReq
);
  fsmCmd_t  cmd;
  tmrStat_t stat;

  link_mon_timers #(
    .TICK_DIV(TICK_DIV), .LOSS_TICKS(LOSS_TICKS),
    .IDLE_TICKS(IDLE_TICKS), .PASS_PULSES(PASS_PULSES)
  ) uTimers (
    .clk(clk), .rstN(rstN), .linkPulseIn(linkPulseIn),
    .rxDataActive(rxDataActive), .txActive(txActive),
    .cmd(cmd), .stat(stat), .idlePulseReq(idlePulseReq)
  );

  link_mon_fsm uFsm (
    .clk(clk), .rstN(rstN), .testLoopback(testLoopback),
    .checkEnable(checkEnable), .stat(stat), .cmd(cmd), .linkFail(linkFail)
  );

  // open-drain LED: 1 means released (pulled high)
  assign linkStatusN = linkFail;
endmodule

// File: tb/tp_link_monitor_test.sv
`timescale 1ns/1ps
module tp_link_monitor_test;
  localparam int D = 4, L = 20, I = 6, P = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0, linkPulseIn = 1'b0, rxDataActive = 1'b0, txActive = 1'b0;
  logic testLoopback = 1'b0, checkEnable = 1'b1;
  logic linkStatusN, linkFail, idlePulseReq;
  int cyc = 0, checks = 0, fails = 0;
  int expQ[$];

  always #10 clk = ~clk;

  tp_link_monitor #(.TICK_DIV(D), .LOSS_TICKS(L), .IDLE_TICKS(I), .PASS_PULSES(P)) uut (
    .clk(clk), .rstN(rstN), .linkPulseIn(linkPulseIn), .rxDataActive(rxDataActive),
    .txActive(txActive), .testLoopback(testLoopback), .checkEnable(checkEnable),
    .linkStatusN(linkStatusN), .linkFail(linkFail), .idlePulseReq(idlePulseReq));

  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  task automatic expectBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor for idle link pulse requests
  always @(negedge clk) begin
    if (idlePulseReq) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R10: actual strobe at cyc %0d expected none", cyc);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R9: actual strobe at cyc %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic waitCyc(int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic drivePulse();
    linkPulseIn = 1'b1;
    @(negedge clk);
    linkPulseIn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    expectBit("R1 linkFail", linkFail, 1'b1);
    expectBit("R1 linkStatusN", linkStatusN, 1'b1);
    expectBit("R1 idlePulseReq", idlePulseReq, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    // Phase A: idle pulse pacing scoreboard
    doReset();
    expQ.push_back(I * D); expQ.push_back(2 * I * D); expQ.push_back(3 * I * D);
    rstN = 1'b1;
    waitCyc(30); checkEnable = 1'b0;          // R9: pacing unaffected
    waitCyc(31);
    expectBit("R7 disabled check pass", linkFail, 1'b0);
    expectBit("R2 status low in pass", linkStatusN, 1'b0);
    waitCyc(70); checkEnable = 1'b1;
    waitCyc(80); txActive = 1'b1;             // R10: suppress
    waitCyc(130); txActive = 1'b0;
    expQ.push_back(152);                      // R10: interval restarts
    waitCyc(153); txActive = 1'b1;
    waitCyc(170);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: actual %0d strobes missing expected 0", expQ.size());
    end

    // Phase B: link check
    doReset();
    rstN = 1'b1;
    idle(3);
    drivePulse();
    expectBit("R5 one pulse keeps fail", linkFail, 1'b1);
    idle(2);
    drivePulse();
    expectBit("R5 second pulse gives pass", linkFail, 1'b0);
    expectBit("R2 status low", linkStatusN, 1'b0);
    for (int k = 0; k < 4; k++) begin
      idle(40);
      drivePulse();
      expectBit("R4 pulses keep pass", linkFail, 1'b0);
    end
    n = 0;
    while (linkFail == 1'b0 && n < 200) begin @(negedge clk); n++; end
    expectBit("R3 loss time in window", (n >= (L-1)*D+1) && (n <= L*D), 1'b1);
    if (n < (L-1)*D+1 || n > L*D) $display("  R3 measured %0d cycles", n);
    expectBit("R2 status released", linkStatusN, 1'b1);
    // R5: timeout between pulses clears the count
    drivePulse();
    idle(100);
    drivePulse();
    expectBit("R5 count cleared by timeout", linkFail, 1'b1);
    drivePulse();
    expectBit("R5 consecutive pulses pass", linkFail, 1'b0);
    // R4: long packet keeps pass
    rxDataActive = 1'b1;
    idle(200);
    expectBit("R4 packet keeps pass", linkFail, 1'b0);
    rxDataActive = 1'b0;
    idle(90);
    expectBit("R3 fail after packet ends", linkFail, 1'b1);
    // R6: one packet recovers
    rxDataActive = 1'b1;
    @(negedge clk);
    rxDataActive = 1'b0;
    expectBit("R6 packet gives pass", linkFail, 1'b0);
    idle(90);
    expectBit("R3 fail again", linkFail, 1'b1);
    // R8: loopback test forces pass
    testLoopback = 1'b1;
    @(negedge clk);
    expectBit("R8 forced pass", linkFail, 1'b0);
    idle(200);
    expectBit("R8 pass held", linkFail, 1'b0);
    testLoopback = 1'b0;
    idle(90);
    expectBit("R3 fail after test", linkFail, 1'b1);
    // R7: disable holds pass
    checkEnable = 1'b0;
    @(negedge clk);
    expectBit("R7 forced pass", linkFail, 1'b0);
    idle(200);
    expectBit("R7 pass held", linkFail, 1'b0);
    checkEnable = 1'b1;
    idle(90);
    expectBit("R3 fail after enable", linkFail, 1'b1);
    // R1: reset from pass
    drivePulse(); drivePulse();
    expectBit("R5 pass before reset", linkFail, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    expectBit("R1 reset gives fail", linkFail, 1'b1);
    expectBit("R1 reset releases status", linkStatusN, 1'b1);
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule